// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between an instruction fetch unit and the decode stage. Fetched bytes arrive in groups of `FETCH_BYTES` and are appended to a small byte queue of `DEPTH` entries. Each entry has its own valid bit. The head of the queue is presented as a three-byte instruction register.

Instructions are one, two or three bytes long. The length is taken from the two top bits of the opcode byte. `00` means one byte, `11` means three bytes, and `01` or `10` means two bytes. The opcode space therefore holds 64 short opcodes, 128 medium opcodes and 64 long opcodes.

The same two bits drive a row of three-input byte multiplexers directly, with no lookup table. When an instruction leaves, these multiplexers slide the remaining bytes forward by one, two or three places. Valid bits never steer data. They only feed the occupancy logic and the issue decision.

The head status is one of three named conditions:
- `HEAD_EMPTY`: no byte is buffered.
- `HEAD_SHORT`: the opcode is present but not all of its bytes are.
- `HEAD_WHOLE`: every byte of the instruction is buffered.

The status moves between these conditions as bytes are fetched, issued or flushed. An instruction issues only in `HEAD_WHOLE` while the consumer is not stalling.

Top module: `aligner`

## Requirements
- R1: `ir_len` gives the byte count of the head instruction as a plain binary number, decoded from opcode bits [7:6]: `00` gives 1, `01` and `10` give 2, `11` gives 3.
- R2: `ir_data[7:0]` holds the opcode byte. `ir_data[15:8]` and `ir_data[23:16]` hold the following bytes in stream order. Only the first `ir_len` bytes carry meaning.
- R3: `ir_valid` is high exactly when the number of buffered bytes is at least one and at least `ir_len`.
- R4: An issue happens on a clock edge where `ir_valid` is high and both `stall` and `flush` are low. The queue then drops exactly `ir_len` bytes, and the next instruction is at the head after that edge.
- R5: While `stall` is high, no byte is consumed and the presented instruction stays unchanged.
- R6: Fetched bytes are accepted on an edge where `fetch_valid` and `fetch_ready` are both high. They are appended after the last byte still buffered once that edge's issue is applied. `fetch_data[7:0]` enters the stream first.
- R7: `fetch_ready` is high exactly when `flush` is low and the free entries (`DEPTH` minus the bytes buffered before this edge) number at least `FETCH_BYTES`.
- R8: A high `flush` empties the queue on the next edge. The head instruction is discarded even if it could issue, and fetch bytes offered in the same cycle are dropped.
- R9: After synchronous reset, `ir_valid` is low and `fetch_ready` is high.
- R10: With no byte buffered, `ir_valid` stays low whatever stale data remains in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all buffered bytes |
| fetch_valid | input | 1 | Fetch group offered |
| fetch_data | input | 8*FETCH_BYTES | Fetch group, earliest byte in the low bits |
| fetch_ready | output | 1 | Queue has room for a whole fetch group |
| stall | input | 1 | Consumer cannot take an instruction |
| ir_valid | output | 1 | Head instruction complete and may issue |
| ir_len | output | 2 | Head instruction length in bytes |
| ir_data | output | 24 | Head instruction bytes |

## Verification
The bench mixes runs of all-short, all-long and randomly mixed instructions. It drops in random stalls, so fetch and issue often land on the same edge. A shift multiplexer wired to the wrong source, or an append that ignores that edge's consumption, would then show up as a reordered or duplicated byte in the scoreboard.

Long instructions are split across fetch groups, so `HEAD_SHORT` is visited often. An aligner that issued on the opcode byte alone would present garbage trailing bytes.

A flush is applied while a fetch is offered and the head could issue. A design that let either through would present an instruction that was never queued after the flush. `fetch_ready` is compared every cycle against the occupancy kept by the bench, which catches off-by-one space accounting.

// File: rtl/aln_pkg.sv
package aln_pkg;

    localparam int BYTE_W = 8;
    localparam int IR_BYTES = 3;

    // select of the three-input shift multiplexers, taken from opcode[7:6]
    typedef enum logic [1:0] {
        SEL_ONE   = 2'd0,
        SEL_TWO   = 2'd1,
        SEL_THREE = 2'd2
    } msel_e;

    // condition of the instruction at the head of the queue
    typedef enum logic [1:0] {
        HEAD_EMPTY,
        HEAD_SHORT,
        HEAD_WHOLE
    } head_e;

endpackage

// File: rtl/aln_lendec.sv
module aln_lendec
    import aln_pkg::*;
(
    input  logic [1:0] top_bits,
    output msel_e      sel,
    output logic [1:0] len
);

    always_comb begin
        unique case (top_bits)
            2'b00: begin
                sel = SEL_ONE;
                len = 2'd1;
            end
            2'b01, 2'b10: begin
                sel = SEL_TWO;
                len = 2'd2;
            end
            2'b11: begin
                sel = SEL_THREE;
                len = 2'd3;
            end
            default: begin
                sel = SEL_ONE;
                len = 2'd1;
            end
        endcase
    end

endmodule

// File: rtl/aln_mux3.sv
module aln_mux3
    import aln_pkg::*;
#(
    parameter int W = 8
) (
    input  msel_e        sel,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] out_y
);

    always_comb begin
        unique case (sel)
            SEL_ONE:   out_y = in_a;
            SEL_TWO:   out_y = in_b;
            SEL_THREE: out_y = in_c;
            default:   out_y = in_a;
        endcase
    end

endmodule

// File: rtl/aln_bytebuf.sv
module aln_bytebuf
    import aln_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int FETCH_BYTES = 2,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          issue,
    input  msel_e                         sel,
    input  logic [1:0]                    len,
    input  logic                          fetch_we,
    input  logic [FETCH_BYTES*BYTE_W-1:0] fetch_data,
    output logic [IR_BYTES*BYTE_W-1:0]    head_bytes,
    output logic [CNT_W-1:0]              count,
    output logic [DEPTH-1:0]              vld
);

    localparam int EXT = DEPTH + IR_BYTES;

    logic [BYTE_W-1:0] mem   [DEPTH];
    logic [BYTE_W-1:0] ext   [EXT];
    logic [BYTE_W-1:0] moved [DEPTH];
    logic [BYTE_W-1:0] mem_n [DEPTH];
    logic [DEPTH-1:0]  vld_n;

    always_comb begin
        for (int i = 0; i < EXT; i++) begin
            ext[i] = (i < DEPTH) ? mem[i] : '0;
        end
    end

    // one shift multiplexer per entry, steered by the opcode bits only
    for (genvar g = 0; g < DEPTH; g++) begin : g_shift
        aln_mux3 #(.W(BYTE_W)) u_mux (
            .sel   (sel),
            .in_a  (ext[g+1]),
            .in_b  (ext[g+2]),
            .in_c  (ext[g+3]),
            .out_y (moved[g])
        );
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++) begin
            count = count + CNT_W'(vld[i]);
        end
    end

    always_comb begin
        int kept;
        int top;
        int off;
        kept = int'(count) - (issue ? int'(len) : 0);
        top  = kept + (fetch_we ? FETCH_BYTES : 0);
        for (int i = 0; i < DEPTH; i++) begin
            mem_n[i] = issue ? moved[i] : mem[i];
            off = i - kept;
            if (fetch_we && off >= 0 && off < FETCH_BYTES) begin
                mem_n[i] = fetch_data[off*BYTE_W +: BYTE_W];
            end
            vld_n[i] = (i < top);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            vld <= flush ? '0 : vld_n;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= mem_n[i];
            end
        end
    end

    assign head_bytes = {mem[2], mem[1], mem[0]};

endmodule

// File: rtl/aligner.sv
module aligner
    import aln_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int FETCH_BYTES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          fetch_valid,
    input  logic [FETCH_BYTES*BYTE_W-1:0] fetch_data,
    output logic                          fetch_ready,
    input  logic                          stall,
    output logic                          ir_valid,
    output logic [1:0]                    ir_len,
    output logic [IR_BYTES*BYTE_W-1:0]    ir_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] buf_count;
    logic [DEPTH-1:0] buf_vld;
    logic [IR_BYTES*BYTE_W-1:0] head;
    msel_e      sel;
    logic [1:0] len;
    head_e      status;
    logic       issue;
    logic       fetch_we;

    aln_lendec u_dec (
        .top_bits (head[7:6]),
        .sel      (sel),
        .len      (len)
    );

    always_comb begin
        if (buf_count == '0) begin
            status = HEAD_EMPTY;
        end else if (int'(buf_count) < int'(len)) begin
            status = HEAD_SHORT;
        end else begin
            status = HEAD_WHOLE;
        end
    end

    always_comb begin
        unique case (status)
            HEAD_EMPTY: ir_valid = 1'b0;
            HEAD_SHORT: ir_valid = 1'b0;
            HEAD_WHOLE: ir_valid = 1'b1;
            default:    ir_valid = 1'b0;
        endcase
    end

    assign issue       = ir_valid && !stall && !flush;
    assign fetch_ready = !flush && (int'(buf_count) + FETCH_BYTES <= DEPTH);
    assign fetch_we    = fetch_valid && fetch_ready;
    assign ir_len      = len;
    assign ir_data     = head;

    aln_bytebuf #(
        .DEPTH       (DEPTH),
        .FETCH_BYTES (FETCH_BYTES)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .issue      (issue),
        .sel        (sel),
        .len        (len),
        .fetch_we   (fetch_we),
        .fetch_data (fetch_data),
        .head_bytes (head),
        .count      (buf_count),
        .vld        (buf_vld)
    );

endmodule

// File: rtl/aligner_chk.sv
module aligner_chk #(
    parameter int DEPTH       = 8,
    parameter int FETCH_BYTES = 2,
    parameter int CNT_W       = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             stall,
    input logic             fetch_valid,
    input logic             fetch_ready,
    input logic             ir_valid,
    input logic [1:0]       ir_len,
    input logic [23:0]      ir_data,
    input logic [CNT_W-1:0] count,
    input logic [DEPTH-1:0] vld
);

    // R1
    a_r1_len_range: assert property (@(posedge clk) disable iff (rst)
        ir_valid |-> (ir_len != 2'd0));

    // R1
    a_r1_len_class: assert property (@(posedge clk) disable iff (rst)
        ir_valid |-> ((ir_data[7:6] == 2'b00) == (ir_len == 2'd1)));

    // R3
    a_r3_enough_bytes: assert property (@(posedge clk) disable iff (rst)
        ir_valid |-> (int'(count) >= int'(ir_len)));

    // R10
    a_r10_empty_head: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !ir_valid);

    // R4
    a_r4_advance: assert property (@(posedge clk) disable iff (rst)
        (ir_valid && !stall && !flush && !(fetch_valid && fetch_ready))
        |=> (int'(count) == int'($past(count)) - int'($past(ir_len))));

    // R5
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (ir_valid && stall && !flush)
        |=> (ir_valid && $stable(ir_data[7:0]) && $stable(ir_len)));

    // R8
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    // R6
    a_r6_valid_prefix: assert property (@(posedge clk) disable iff (rst)
        ((vld + 1'b1) & vld) == '0);

    // R7
    a_r7_ready_space: assert property (@(posedge clk) disable iff (rst)
        fetch_ready |-> (int'(count) + FETCH_BYTES <= DEPTH));

endmodule

bind aligner aligner_chk #(
    .DEPTH       (DEPTH),
    .FETCH_BYTES (FETCH_BYTES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .stall       (stall),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .ir_valid    (ir_valid),
    .ir_len      (ir_len),
    .ir_data     (ir_data),
    .count       (buf_count),
    .vld         (buf_vld)
);

// File: tb/test_aligner.sv
module test_aligner;

    localparam int DEPTH = 8;
    localparam int FB    = 2;

    typedef struct packed {
        logic [1:0]  len;
        logic [23:0] data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          flush;
    logic          fetch_valid;
    logic [FB*8-1:0] fetch_data;
    logic          fetch_ready;
    logic          stall;
    logic          ir_valid;
    logic [1:0]    ir_len;
    logic [23:0]   ir_data;

    always #2 clk = ~clk;

    aligner #(.DEPTH(DEPTH), .FETCH_BYTES(FB)) i_aligner (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .fetch_ready (fetch_ready),
        .stall       (stall),
        .ir_valid    (ir_valid),
        .ir_len      (ir_len),
        .ir_data     (ir_data)
    );

    item_t      exp_q[$];
    logic [7:0] byte_q[$];
    int  checks = 0;
    int  fails  = 0;
    int  cnt    = 0;
    bit  ended  = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic finish_test();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // driver: queue an instruction's bytes and its expected result
    task automatic push_instr(int len, logic [7:0] seed);
        item_t it;
        logic [1:0] top;
        logic [7:0] b0, b1, b2;
        top = (len == 1) ? 2'b00 : (len == 3) ? 2'b11 : (seed[0] ? 2'b01 : 2'b10);
        b0 = {top, seed[5:0]};
        b1 = seed ^ 8'h5A;
        b2 = seed + 8'h33;
        it.len  = 2'(len);
        it.data = {(len > 2) ? b2 : 8'h00, (len > 1) ? b1 : 8'h00, b0};
        exp_q.push_back(it);
        byte_q.push_back(b0);
        if (len > 1) byte_q.push_back(b1);
        if (len > 2) byte_q.push_back(b2);
    endtask

    // one cycle: monitor compares the head, then drives next inputs
    task automatic cycle(bit stall_v);
        item_t it;
        logic [23:0] mask;
        bit exp_iv;
        bit exp_rdy;
        @(negedge clk);
        stall = stall_v;
        flush = 1'b0;
        #1;
        exp_rdy = (DEPTH - cnt) >= FB;
        chk("R7 fetch_ready", 32'(fetch_ready), 32'(exp_rdy));
        exp_iv = (cnt > 0) && (exp_q.size() > 0) && (cnt >= int'(exp_q[0].len));
        chk("R3 ir_valid", 32'(ir_valid), 32'(exp_iv));
        if (exp_iv && !stall_v) begin
            it = exp_q.pop_front();
            mask = (it.len == 2'd1) ? 24'h0000FF : (it.len == 2'd2) ? 24'h00FFFF : 24'hFFFFFF;
            chk("R1 ir_len", 32'(ir_len), 32'(it.len));
            chk("R2 ir_data", 32'(ir_data & mask), 32'(it.data));
            cnt -= int'(it.len);
        end
        if (exp_rdy && byte_q.size() > 0) begin
            for (int k = 0; k < FB; k++) begin
                if (byte_q.size() > 0) begin
                    fetch_data[k*8 +: 8] = byte_q.pop_front();
                end else begin
                    fetch_data[k*8 +: 8] = 8'h00;
                    exp_q.push_back('{len: 2'd1, data: 24'h0});
                end
            end
            fetch_valid = 1'b1;
            cnt += FB;
        end else begin
            fetch_valid = 1'b0;
        end
    endtask

    task automatic drain(bit rnd_stall, string tag);
        int n;
        n = 0;
        while ((exp_q.size() > 0 || byte_q.size() > 0) && n < 5000) begin
            lfsr = step(lfsr);
            cycle(rnd_stall && (lfsr[1:0] == 2'b00));
            n++;
        end
        chk({tag, " drained"}, 32'(exp_q.size() + byte_q.size()), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_test();
    end

    initial begin
        logic [23:0] held;
        rst = 1'b1; flush = 1'b0; stall = 1'b0;
        fetch_valid = 1'b0; fetch_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 ir_valid after reset", 32'(ir_valid), 32'd0);
        chk("R9 fetch_ready after reset", 32'(fetch_ready), 32'd1);

        // all one-byte instructions (R4, R6)
        for (int i = 0; i < 12; i++) push_instr(1, 8'(i * 7 + 1));
        drain(0, "R4 short run");

        // all three-byte instructions, split across fetch groups (R3, R6)
        for (int i = 0; i < 9; i++) push_instr(3, 8'(i * 13 + 5));
        drain(0, "R6 long run");

        // mixed lengths with random stalls (R1, R2, R4, R5)
        for (int i = 0; i < 200; i++) begin
            lfsr = step(lfsr);
            push_instr((lfsr[3:2] == 2'b00) ? 1 : (lfsr[3:2] == 2'b11) ? 3 : 2, lfsr[11:4]);
        end
        drain(1, "R5 mixed with stalls");

        // long stall: head held unchanged (R5)
        push_instr(3, 8'h91);
        push_instr(2, 8'h22);
        repeat (4) cycle(1);
        held = ir_data;
        repeat (3) cycle(1);
        chk("R5 ir_data held under stall", 32'(ir_data[7:0]), 32'(held[7:0]));
        chk("R5 ir_len held under stall", 32'(ir_len), 32'd3);
        drain(0, "R5 release");

        // flush with a fetch offered and an issuable head (R8, R10)
        for (int i = 0; i < 6; i++) push_instr(2, 8'(40 + i));
        repeat (4) cycle(0);
        @(negedge clk);
        flush = 1'b1; stall = 1'b0;
        fetch_valid = 1'b1; fetch_data = 16'hC3C3;
        @(negedge clk);
        flush = 1'b0; fetch_valid = 1'b0;
        exp_q.delete(); byte_q.delete(); cnt = 0;
        #1;
        chk("R8 ir_valid after flush", 32'(ir_valid), 32'd0);
        chk("R8 fetch_ready after flush", 32'(fetch_ready), 32'd1);
        @(negedge clk);
        #1;
        chk("R10 stale head not valid", 32'(ir_valid), 32'd0);
        push_instr(1, 8'h07);
        push_instr(3, 8'hE4);
        drain(0, "R8 after flush");

        finish_test();
    end

endmodule